// File: doc/BRIEF.md
# Windowed Command Bus Rate Limiter

This block sits in front of a shared memory command bus. It decides when each command may actually be placed there. Time is split into aligned windows of a fixed length. No window may carry more than a fixed number of commands.

A requester presents a desired issue cycle together with a flag that marks a two-part command. The block walks forward through the windows until it finds a slot that fits. It then returns the granted cycle, or both cycles for a two-part command, and records the new occupancy in a small table of per-window counters. Windows that lie wholly behind the current time are dropped from that table. The current time comes from the `cur_time` input.

Each request is accepted with a valid/ready handshake and answered with a single response pulse. While a request is being placed, no new request is accepted. If no table entry is free for a window that must be recorded, the block holds its answer and raises `busy`. It stays there until an advance of `cur_time` lets stale windows be dropped.

Top module: `cmd_window_limiter`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `busy` is 0.
- R2: The window of a cycle t is t with its low WIN_LOG2 bits cleared (window length 2^WIN_LOG2, default 8), and a command moved out of a window lands on the first cycle of the following window.
- R3: A single command (`req_pair`=0) is granted its requested cycle if that window holds fewer than MAX_CMDS commands. Otherwise it moves to the next window start and is checked again, repeatedly through any run of full windows.
- R4: Every granted half adds one to its window's count, and no window count ever exceeds MAX_CMDS (default 2).
- R5: For a two-part command (`req_pair`=1), the first half is placed by the R3 rule. The second half is placed one cycle after the first if that window still has room, otherwise at the start of a later window. It is always strictly later than the first half and at most MAX_SPLIT (default 5) cycles after it.
- R6: When the second half cannot be placed within MAX_SPLIT, the whole pair restarts with its first half at the start of the window following the first half's window.
- R7: A granted first-half cycle is never earlier than the requested cycle.
- R8: When a request is accepted, table entries whose window start is below the window of `cur_time` are dropped first, so those windows count as empty.
- R9: When a window must be recorded and no entry is free, `busy` is 1 and no response is given. Stale entries are dropped every cycle in that state, and the response follows once an entry frees up.
- R10: `req_ready` is 1 only while idle, and each accepted request produces exactly one single-cycle `resp_valid` pulse carrying `resp_time_a`, `resp_time_b` (equal to `resp_time_a` for single commands) and `resp_pair`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | TW | Current cycle, used to drop stale windows |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_time | input | TW | Desired issue cycle |
| req_pair | input | 1 | 1 for a two-part command |
| resp_valid | output | 1 | One-cycle pulse with the granted times |
| resp_time_a | output | TW | Granted cycle of the (first) command |
| resp_time_b | output | TW | Granted cycle of the second half |
| resp_pair | output | 1 | Echo of the request's pair flag |
| busy | output | 1 | Placement stalled for lack of a free table entry |

## Verification
A wrong count in the occupancy table shows up in the granted cycle of the next request that falls into that window.

- A count that is too low lets a command stay in a window that should already be full.
- A count that is too high pushes a command one window further than expected.

Either way the error appears on the next response, not on the request that caused it. The bench therefore replays chains of requests whose expected grants depend on the counts left behind by earlier ones.

A missed prune surfaces as a late grant or as a `busy` stall on the first request after `cur_time` advances.

// File: rtl/cmd_window_limiter.sv
module cmd_window_limiter #(
  parameter int TW        = 16,
  parameter int WIN_LOG2  = 3,
  parameter int MAX_CMDS  = 2,
  parameter int MAX_SPLIT = 5,
  parameter int ENTRIES   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cur_time,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [TW-1:0] req_time,
  input  logic          req_pair,
  output logic          resp_valid,
  output logic [TW-1:0] resp_time_a,
  output logic [TW-1:0] resp_time_b,
  output logic          resp_pair,
  output logic          busy
);

  localparam int CW = $clog2(MAX_CMDS + 1);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [TW-1:0] LMASK = TW'((1 << WIN_LOG2) - 1);
  localparam logic [TW-1:0] WLEN  = TW'(1 << WIN_LOG2);
  localparam logic [TW-1:0] SPLIT = TW'(MAX_SPLIT);
  localparam logic [CW:0]   MAXV  = (CW+1)'(MAX_CMDS);

  typedef enum logic [2:0] {S_IDLE, S_A, S_B, S_CA, S_CB} state_t;

  state_t        state;
  logic [TW-1:0] t_req, ta, tb;
  logic          pair_q;

  logic          ent_v [ENTRIES];
  logic [TW-1:0] ent_w [ENTRIES];
  logic [CW-1:0] ent_c [ENTRIES];

  logic [TW-1:0] look_w, wa, wb, cur_w, nb;
  logic          hit, free;
  logic [IW-1:0] hit_idx, free_idx;
  logic [CW:0]   look_cnt, occ_b;
  logic          accept, commit, prune;

  assign accept = req_valid && req_ready;
  assign req_ready = (state == S_IDLE);
  assign wa = ta & ~LMASK;
  assign wb = tb & ~LMASK;
  assign cur_w = cur_time & ~LMASK;
  assign nb = wb + WLEN;
  assign look_w = (state == S_B || state == S_CB) ? wb : wa;
  assign occ_b = look_cnt + ((wb == wa) ? (CW+1)'(1) : '0);
  assign commit = (state == S_CA || state == S_CB) && (hit || free);
  assign busy = (state == S_CA || state == S_CB) && !hit && !free;
  assign prune = accept || busy;

  always_comb begin
    hit = 1'b0;
    free = 1'b0;
    hit_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_w[i] == look_w) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
      if (!ent_v[i]) begin
        free = 1'b1;
        free_idx = IW'(i);
      end
    end
    look_cnt = hit ? {1'b0, ent_c[hit_idx]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i] <= 1'b0;
        ent_w[i] <= '0;
        ent_c[i] <= '0;
      end
    end else if (prune) begin
      for (int i = 0; i < ENTRIES; i++)
        if (ent_v[i] && ent_w[i] < cur_w) ent_v[i] <= 1'b0;
    end else if (commit) begin
      if (hit) begin
        ent_c[hit_idx] <= ent_c[hit_idx] + CW'(1);
      end else begin
        ent_v[free_idx] <= 1'b1;
        ent_w[free_idx] <= look_w;
        ent_c[free_idx] <= CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      t_req <= '0;
      ta <= '0;
      tb <= '0;
      pair_q <= 1'b0;
      resp_valid <= 1'b0;
      resp_time_a <= '0;
      resp_time_b <= '0;
      resp_pair <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          t_req <= req_time;
          ta <= req_time;
          pair_q <= req_pair;
          state <= S_A;
        end
        S_A: begin
          if (look_cnt < MAXV) begin
            if (pair_q) begin
              tb <= ta + TW'(1);
              state <= S_B;
            end else begin
              tb <= ta;
              state <= S_CA;
            end
          end else begin
            ta <= wa + WLEN;
          end
        end
        S_B: begin
          if (occ_b < MAXV) begin
            state <= S_CA;
          end else if (nb > ta + SPLIT) begin
            ta <= wa + WLEN;
            state <= S_A;
          end else begin
            tb <= nb;
          end
        end
        S_CA: if (commit) begin
          if (pair_q) begin
            state <= S_CB;
          end else begin
            state <= S_IDLE;
            resp_valid <= 1'b1;
            resp_time_a <= ta;
            resp_time_b <= ta;
            resp_pair <= 1'b0;
          end
        end
        S_CB: if (commit) begin
          state <= S_IDLE;
          resp_valid <= 1'b1;
          resp_time_a <= ta;
          resp_time_b <= tb;
          resp_pair <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ent_v[g] |-> ({1'b0, ent_c[g]} <= MAXV));
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ent_v[g] |-> ((ent_w[g] & LMASK) == '0));
  end

  a_r7_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_time_a >= t_req));

  a_r5_split: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_pair) |-> ((resp_time_b > resp_time_a) &&
                                   (resp_time_b - resp_time_a <= SPLIT)));

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r10_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !resp_valid);

endmodule

// File: tb/cmd_window_limiter_test.sv
`timescale 1ns/100ps
module cmd_window_limiter_test;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cur_time = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [TW-1:0] req_time = '0;
  logic          req_pair = 1'b0;
  logic          resp_valid;
  logic [TW-1:0] resp_time_a, resp_time_b;
  logic          resp_pair;
  logic          busy;

  int vectors = 0;
  int miscompares = 0;
  int resp_seen = 0;

  int    q_req[$];
  int    q_a[$];
  int    q_b[$];
  int    q_p[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  cmd_window_limiter uut (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_time(req_time), .req_pair(req_pair),
    .resp_valid(resp_valid), .resp_time_a(resp_time_a),
    .resp_time_b(resp_time_b), .resp_pair(resp_pair), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int t, input bit pr, input int ea, input int eb, input string tag);
    q_req.push_back(t);
    q_a.push_back(ea);
    q_b.push_back(pr ? eb : ea);
    q_p.push_back(int'(pr));
    q_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_time = TW'(t);
    req_pair = pr;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready || q_a.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      resp_seen++;
      if (q_a.size() == 0) begin
        check(1'b0, "R10 unexpected response", 1, 0);
      end else begin
        int r, a, b, p;
        string tag;
        r = q_req.pop_front();
        a = q_a.pop_front();
        b = q_b.pop_front();
        p = q_p.pop_front();
        tag = q_tag.pop_front();
        check(int'(resp_time_a) == a, {tag, " first time"}, int'(resp_time_a), a);
        check(int'(resp_time_b) == b, {tag, " second time"}, int'(resp_time_b), b);
        check(int'(resp_pair) == p, "R10 pair echo", int'(resp_pair), p);
        check(int'(resp_time_a) >= r, "R7 not before request", int'(resp_time_a), r);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
    check(busy == 1'b0, "R1 not busy after reset", int'(busy), 0);

    send(3, 0, 3, 0, "R3 single in empty window");
    send(5, 0, 5, 0, "R4 second in window");
    send(7, 0, 8, 0, "R2 moved to next window start");
    send(9, 1, 16, 17, "R6 pair restarts in later window");
    send(12, 1, 24, 25, "R6 pair skips full window");
    settle();

    send(30, 0, 32, 0, "R9 granted after stall");
    seen = resp_seen;
    repeat (12) @(negedge clk);
    check(busy == 1'b1, "R9 busy with full table", int'(busy), 1);
    check(resp_seen == seen, "R9 no response while busy", resp_seen, seen);
    cur_time = 16'd8;
    settle();
    check(busy == 1'b0, "R9 busy clears", int'(busy), 0);

    cur_time = 16'd24;
    send(17, 0, 17, 0, "R8 pruned window counts empty");
    send(33, 0, 33, 0, "R4 window fills to max");
    send(26, 0, 40, 0, "R3 chain through full windows");
    settle();

    cur_time = 16'd40;
    send(47, 1, 47, 48, "R5 second half in next window");
    send(49, 1, 56, 57, "R6 split exceeded");
    send(65, 1, 65, 66, "R5 both halves same window");
    settle();
    cur_time = 16'd80;
    send(87, 1, 87, 88, "R5 first half on last slot");
    settle();

    @(negedge clk);
    check(req_ready == 1'b1, "R10 idle at end", int'(req_ready), 1);
    check(q_a.size() == 0, "R10 all answered", q_a.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule